// File: doc/BRIEF.md
# Vector Element Predicate Mask Unit

This block decides, element by element, whether a vector operation of length VL may write its destination. When an operation starts, the unit captures the operation's configuration. This is the mask source, an invert flag, a result-record flag, the vector length, a 64-bit integer mask and a 32-bit condition register. It then answers one question per step: is the element named by the step index enabled? A disabled element must leave its destination untouched. An all-zero flag tells the issuing logic that no element in range is enabled, so the whole operation can be dropped without changing anything.

There are two mask sources. In integer mode, bit i of the captured mask governs element i. In condition mode, element i reads the equality bit of condition field 4+i. In both modes the invert flag turns the sense around, so a then-branch and an else-branch can share one mask. When result recording is on, each enabled element also gets a 4-bit condition code: less, greater, equal, and a zero summary bit. The code comes from comparing the element's signed result against zero and is meant for condition field i.

Top module: `pmask_top`

## Requirements
- R1: While reset is asserted and after it is released, `elemEn` and `crWrEn` are 0 and `allZero` is 1 until the first start.
- R2: In integer mode (`srcSel`=0, `invert`=0), a step with index i asserts `elemEn` in the same cycle exactly when bit i of the captured `intMask` is 1 and i < VL. For example, mask 3'b101 with VL=3 enables elements 0 and 2 only.
- R3: In integer mode with `invert`=1, element i is enabled exactly when captured mask bit i is 0 and i < VL.
- R4: In condition mode (`srcSel`=1), element i reads the equality bit of field 4+i. Field n sits at bit offset (7−n)×4 of `condReg`, and the equality bit has weight 4'b0010 within its field, so element i reads `condReg[13−4i]`. The element is enabled when that bit is 1, or when it is 0 if `invert`=1.
- R5: In condition mode, elements 4 and above have no condition field and are disabled whether or not `invert` is set.
- R6: One cycle after a start, `allZero` is 1 exactly when no element 0..VL−1 is enabled once inversion is applied. VL=0 gives 1. Mask bits at or above VL do not count. The flag holds until the next start.
- R7: `srcSel`, `invert`, `recEn`, `vecLen`, `intMask` and `condReg` are sampled only in the cycle `start` is high. Changing them during an operation has no effect on the enables of that operation.
- R8: An operation is active from the cycle after `start` until a step whose index is ≥ VL−1. Steps outside an active operation, including a step presented in the same cycle as `start`, give `elemEn`=0.
- R9: `crBits` is {lt,gt,eq,0} for the signed `resultVal` compared with zero. This gives 4'b1000 for a negative result, 4'b0100 for a positive one and 4'b0010 for zero. `crWrEn` is high exactly when `elemEn` is high and `recEn` was captured as 1.
- R10: A step index ≥ VL never enables an element, whatever the mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation and capture its configuration |
| srcSel | input | 1 | Mask source: 0 integer bits, 1 condition fields |
| invert | input | 1 | Enable on a mask bit of 0 instead of 1 |
| recEn | input | 1 | Produce condition-code write-back for enabled elements |
| vecLen | input | 7 | Vector length VL, clamped to 64 |
| intMask | input | 64 | Integer predicate bits |
| condReg | input | 32 | Eight 4-bit condition fields, field 0 in the top nibble |
| stepValid | input | 1 | A step is presented this cycle |
| stepIdx | input | 6 | Element number of the step |
| resultVal | input | 64 | Element result used for the condition code |
| elemEn | output | 1 | The presented element may be written |
| allZero | output | 1 | No element of the current operation is enabled |
| crWrEn | output | 1 | Write `crBits` into condition field `stepIdx` |
| crBits | output | 4 | Condition code {lt,gt,eq,0} of `resultVal` |

## Verification
The hardest case to reach from the ports is the interaction between capture and the operation boundary. Inputs must change in the middle of an operation, and a step must arrive in the same cycle as `start` or after the last element. The stimulus starts an operation and then, while stepping, rewrites every configuration input to values that would flip each enable. It also presents a step together with `start`, and keeps stepping after the final element. A condition-mode run with VL above four, with the invert flag set, drives the missing-field elements that inversion must not wake up.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

  typedef enum logic [0:0] {
    SRC_INT  = 1'b0,
    SRC_COND = 1'b1
  } srcSel_e;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic load;   // capture the configuration this cycle
    logic run;    // an operation is in progress
  } ctrlStrobe_t;

  // Captured per-operation mode bits
  typedef struct packed {
    srcSel_e src;
    logic    inv;
    logic    rec;
  } opCfg_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } opState_e;

endpackage

// File: rtl/pmask_ctrl.sv
module pmask_ctrl
  import pmask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stepValid,
  input  logic        lastStep,
  output ctrlStrobe_t strobe
);

  opState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    if (start) begin
      stateD = ST_RUN;
    end else if (stateQ == ST_RUN && stepValid && lastStep) begin
      stateD = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    strobe.load = start;
    strobe.run  = (stateQ == ST_RUN);
  end

endmodule

// File: rtl/pmask_dp.sv
module pmask_dp
  import pmask_pkg::*;
#(
  parameter int MAX_VL     = 64,
  parameter int XLEN       = 64,
  parameter int CR_FIELDS  = 8,
  parameter int FIELD_W    = 4,
  parameter int EQ_POS     = 1,
  parameter int COND_BASE  = 4,
  parameter int VL_W       = $clog2(MAX_VL + 1),
  parameter int IDX_W      = $clog2(MAX_VL),
  parameter int CR_W       = CR_FIELDS * FIELD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             srcSel,
  input  logic             invert,
  input  logic             recEn,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [XLEN-1:0]  intMask,
  input  logic [CR_W-1:0]  condReg,
  input  logic             stepValid,
  input  logic [IDX_W-1:0] stepIdx,
  input  logic [XLEN-1:0]  resultVal,
  output logic             elemEn,
  output logic             allZero,
  output logic             crWrEn,
  output logic [3:0]       crBits,
  output logic             lastStep,
  output logic [VL_W-1:0]  heldVl
);

  localparam int SLOTS = 1 << IDX_W;
  localparam int CMP_W = (IDX_W + 1 > VL_W) ? IDX_W + 1 : VL_W;

  opCfg_t                cfgQ;
  logic [VL_W-1:0]       vlQ;
  logic [XLEN-1:0]       intMaskQ;
  logic [CR_FIELDS-1:0]  condEqQ;
  logic [CR_FIELDS-1:0]  condEqD;
  logic [VL_W-1:0]       vlClamped;
  logic [SLOTS-1:0]      effMask;

  // Pull the equality bit out of every condition field
  for (genvar n = 0; n < CR_FIELDS; n++) begin : gEqPick
    localparam int BITPOS = (CR_FIELDS - 1 - n) * FIELD_W + EQ_POS;
    assign condEqD[n] = condReg[BITPOS];
  end

  assign vlClamped = (vecLen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vecLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '{src: SRC_INT, inv: 1'b0, rec: 1'b0};
      vlQ      <= '0;
      intMaskQ <= '0;
      condEqQ  <= '0;
    end else if (strobe.load) begin
      cfgQ     <= '{src: srcSel_e'(srcSel), inv: invert, rec: recEn};
      vlQ      <= vlClamped;
      intMaskQ <= intMask;
      condEqQ  <= condEqD;
    end
  end

  // Effective per-element enable vector for the captured operation
  for (genvar i = 0; i < SLOTS; i++) begin : gElem
    if (i < MAX_VL && i < XLEN) begin : gLive
      logic inRange;
      logic condBit;
      assign inRange = (vlQ > VL_W'(i));
      if (COND_BASE + i < CR_FIELDS) begin : gHasField
        assign condBit = condEqQ[COND_BASE + i] ^ cfgQ.inv;
      end else begin : gNoField
        assign condBit = 1'b0;
      end
      assign effMask[i] = inRange &
                          ((cfgQ.src == SRC_COND) ? condBit
                                                  : (intMaskQ[i] ^ cfgQ.inv));
    end else begin : gPad
      assign effMask[i] = 1'b0;
    end
  end

  assign allZero = ~|effMask;
  assign elemEn  = strobe.run & stepValid & effMask[stepIdx];
  assign crWrEn  = cfgQ.rec & elemEn;
  assign lastStep = (CMP_W'(stepIdx) + CMP_W'(1)) >= CMP_W'(vlQ);
  assign heldVl  = vlQ;

  // Signed comparison of the element result with zero
  always_comb begin
    if (resultVal[XLEN-1]) begin
      crBits = 4'b1000;
    end else if (resultVal == '0) begin
      crBits = 4'b0010;
    end else begin
      crBits = 4'b0100;
    end
  end

endmodule

// File: rtl/pmask_top.sv
module pmask_top
  import pmask_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int XLEN   = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             srcSel,
  input  logic             invert,
  input  logic             recEn,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [XLEN-1:0]  intMask,
  input  logic [31:0]      condReg,
  input  logic             stepValid,
  input  logic [IDX_W-1:0] stepIdx,
  input  logic [XLEN-1:0]  resultVal,
  output logic             elemEn,
  output logic             allZero,
  output logic             crWrEn,
  output logic [3:0]       crBits
);

  ctrlStrobe_t     strobe;
  logic            lastStep;
  logic [VL_W-1:0] heldVl;

  pmask_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stepValid (stepValid),
    .lastStep  (lastStep),
    .strobe    (strobe)
  );

  pmask_dp #(
    .MAX_VL    (MAX_VL),
    .XLEN      (XLEN),
    .CR_FIELDS (8),
    .FIELD_W   (4),
    .EQ_POS    (1),
    .COND_BASE (4),
    .VL_W      (VL_W),
    .IDX_W     (IDX_W),
    .CR_W      (32)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcSel    (srcSel),
    .invert    (invert),
    .recEn     (recEn),
    .vecLen    (vecLen),
    .intMask   (intMask),
    .condReg   (condReg),
    .stepValid (stepValid),
    .stepIdx   (stepIdx),
    .resultVal (resultVal),
    .elemEn    (elemEn),
    .allZero   (allZero),
    .crWrEn    (crWrEn),
    .crBits    (crBits),
    .lastStep  (lastStep),
    .heldVl    (heldVl)
  );

endmodule

// File: rtl/pmask_chk.sv
module pmask_chk #(
  parameter int VL_W  = 7,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             stepValid,
  input logic [IDX_W-1:0] stepIdx,
  input logic             elemEn,
  input logic             allZero,
  input logic             crWrEn,
  input logic [3:0]       crBits,
  input logic [VL_W-1:0]  heldVl
);

  localparam int CMP_W = (IDX_W > VL_W) ? IDX_W : VL_W;

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!elemEn && !crWrEn && allZero); // R1
    end
  end

  AST_EN_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    elemEn |-> stepValid); // R2

  AST_ZERO_BLOCKS_EN: assert property (@(posedge clk) disable iff (!rstN)
    allZero |-> !elemEn); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(start) |-> $stable(heldVl)); // R7

  AST_CR_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> elemEn); // R9

  AST_CR_CODE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (crBits[0] == 1'b0) && ($countones(crBits[3:1]) == 1)); // R9

  AST_EN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    elemEn |-> (CMP_W'(stepIdx) < CMP_W'(heldVl))); // R10

endmodule

bind pmask_top pmask_chk #(
  .VL_W  (VL_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .stepValid (stepValid),
  .stepIdx   (stepIdx),
  .elemEn    (elemEn),
  .allZero   (allZero),
  .crWrEn    (crWrEn),
  .crBits    (crBits),
  .heldVl    (heldVl)
);

// File: tb/pmask_top_bench.sv
`timescale 1ns/1ps
module pmask_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        srcSel = 1'b0;
  logic        invert = 1'b0;
  logic        recEn = 1'b0;
  logic [6:0]  vecLen = '0;
  logic [63:0] intMask = '0;
  logic [31:0] condReg = '0;
  logic        stepValid = 1'b0;
  logic [5:0]  stepIdx = '0;
  logic [63:0] resultVal = '0;
  logic        elemEn;
  logic        allZero;
  logic        crWrEn;
  logic [3:0]  crBits;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curTag = "R1";

  always #4 clk = ~clk;

  pmask_top u_pmask_top (
    .clk(clk), .rstN(rstN), .start(start), .srcSel(srcSel), .invert(invert),
    .recEn(recEn), .vecLen(vecLen), .intMask(intMask), .condReg(condReg),
    .stepValid(stepValid), .stepIdx(stepIdx), .resultVal(resultVal),
    .elemEn(elemEn), .allZero(allZero), .crWrEn(crWrEn), .crBits(crBits)
  );

  // ---------------- behavioural reference ----------------
  bit          mRun = 0, mSel = 0, mInv = 0, mRec = 0;
  int          mVl = 0;
  logic [63:0] mInt = '0;
  logic [31:0] mCr = '0;

  function automatic bit refBit(int i);
    if (i >= mVl) return 0;
    if (!mSel) return mInt[i] ^ mInv;
    if (4 + i > 7) return 0;
    return mCr[(7 - (4 + i)) * 4 + 1] ^ mInv;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mSel = 0; mInv = 0; mRec = 0; mVl = 0; mInt = '0; mCr = '0;
    end else if (start) begin
      mRun = 1; mSel = srcSel; mInv = invert; mRec = recEn;
      mVl = (int'(vecLen) > 64) ? 64 : int'(vecLen);
      mInt = intMask; mCr = condReg;
    end else if (mRun && stepValid && (int'(stepIdx) + 1 >= mVl)) begin
      mRun = 0;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expEn;
      bit expAz;
      logic [3:0] expCr;
      expEn = mRun && stepValid && refBit(int'(stepIdx));
      expAz = 1;
      for (int i = 0; i < mVl; i++) if (refBit(i)) expAz = 0;
      if ($signed(resultVal) < 0) expCr = 4'b1000;
      else if (resultVal == 0)    expCr = 4'b0010;
      else                        expCr = 4'b0100;
      check(curTag, {63'b0, elemEn}, {63'b0, expEn});
      check("R6", {63'b0, allZero}, {63'b0, expAz});
      check("R9", {63'b0, crWrEn}, {63'b0, expEn & mRec});
      check("R9", {60'b0, crBits}, {60'b0, expCr});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic doStart(bit sel, bit inv, bit rec, int vl,
                         logic [63:0] im, logic [31:0] cr);
    start = 1; srcSel = sel; invert = inv; recEn = rec;
    vecLen = 7'(vl); intMask = im; condReg = cr;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic doStep(int idx, logic [63:0] res, bit expEn, string tag);
    stepValid = 1; stepIdx = 6'(idx); resultVal = res;
    @(negedge clk);
    check(tag, {63'b0, elemEn}, {63'b0, expEn});
    @(posedge clk); #1;
    stepValid = 0;
  endtask

  task automatic checkAz(bit exp, string tag);
    @(negedge clk);
    check(tag, {63'b0, allZero}, {63'b0, exp});
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    check("R1", {62'b0, elemEn, crWrEn}, 64'd0);
    check("R1", {63'b0, allZero}, 64'd1);
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check("R1", {62'b0, elemEn, crWrEn}, 64'd0);
    @(posedge clk); #1;

    // R2: integer mask 101
    curTag = "R2";
    doStart(0, 0, 0, 3, 64'b101, '0);
    doStep(0, 1, 1, "R2"); doStep(1, 1, 0, "R2"); doStep(2, 1, 1, "R2");

    // R3: inverted integer mask
    curTag = "R3";
    doStart(0, 1, 0, 3, 64'b101, '0);
    doStep(0, 1, 0, "R3"); doStep(1, 1, 1, "R3"); doStep(2, 1, 0, "R3");

    // R4: field 4 eq=1, field 5 eq=0
    curTag = "R4";
    doStart(1, 0, 0, 2, '0, 32'h0000_2000);
    doStep(0, 1, 1, "R4"); doStep(1, 1, 0, "R4");
    doStart(1, 1, 0, 2, '0, 32'h0000_2000);
    doStep(0, 1, 0, "R4"); doStep(1, 1, 1, "R4");

    // R5: no field beyond element 3, even when inverted
    curTag = "R5";
    doStart(1, 1, 0, 6, '1, 32'h0);
    doStep(3, 1, 1, "R5"); doStep(4, 1, 0, "R5"); doStep(5, 1, 0, "R5");

    // R6: all-zero flag
    curTag = "R6";
    doStart(0, 0, 0, 3, 64'h0, '0);
    checkAz(1, "R6");
    doStep(2, 1, 0, "R6");
    doStart(0, 0, 0, 3, 64'h20, '0);
    checkAz(1, "R6");
    doStep(2, 1, 0, "R6");
    doStart(0, 0, 0, 0, '1, '0);
    checkAz(1, "R6");
    doStep(0, 1, 0, "R6");
    doStart(0, 1, 0, 4, 64'h7, '0);
    checkAz(0, "R6");
    doStep(3, 1, 1, "R6");

    // R7: inputs changed mid-operation are ignored
    curTag = "R7";
    doStart(0, 0, 0, 3, 64'b101, '0);
    intMask = 64'b010; invert = 1; vecLen = 7'd1; srcSel = 1; recEn = 1;
    doStep(0, 1, 1, "R7"); doStep(1, 1, 0, "R7");
    check("R7", {63'b0, crWrEn}, 64'd0);
    doStep(2, 1, 1, "R7");
    srcSel = 0; invert = 0; recEn = 0;

    // R8: step with start is ignored; steps after end are ignored
    curTag = "R8";
    stepValid = 1; stepIdx = 0;
    start = 1; vecLen = 7'd2; intMask = '1;
    @(negedge clk);
    check("R8", {63'b0, elemEn}, 64'd0);
    @(posedge clk); #1;
    start = 0; stepValid = 0;
    doStep(0, 1, 1, "R8"); doStep(1, 1, 1, "R8"); doStep(0, 1, 0, "R8");

    // R9: condition code write-back
    curTag = "R9";
    doStart(0, 0, 1, 4, 64'b0111, '0);
    stepValid = 1; stepIdx = 0; resultVal = 64'd0;
    @(negedge clk);
    check("R9", {60'b0, crBits}, 64'b0010);
    check("R9", {63'b0, crWrEn}, 64'd1);
    @(posedge clk); #1;
    stepIdx = 1; resultVal = 64'd5;
    @(negedge clk);
    check("R9", {60'b0, crBits}, 64'b0100);
    @(posedge clk); #1;
    stepIdx = 2; resultVal = '1;
    @(negedge clk);
    check("R9", {60'b0, crBits}, 64'b1000);
    @(posedge clk); #1;
    stepIdx = 3; resultVal = 64'd9;
    @(negedge clk);
    check("R9", {63'b0, crWrEn}, 64'd0);
    @(posedge clk); #1;
    stepValid = 0;

    // R10: index past VL
    curTag = "R10";
    doStart(0, 0, 0, 2, '1, '0);
    doStep(3, 1, 0, "R10");

    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule